// File: doc/BRIEF.md
# Rectangle DMA Engine

The engine moves a rectangular region of 32-bit pixels between frame buffers in a shared word-wide memory, or paints a region with one constant colour. Software sets up three layers: foreground, background and output. Each layer has a start-address register and a skip count. The start address already includes the rectangle's corner: base plus x times 4 plus y times the row stride in bytes. A single size register gives the pixels per line and the number of lines. A write to the control register with the go bit set starts the job.

The engine walks the rectangle line by line. After every pixel, each layer's address advances by 4 bytes. At the end of each line, it also advances by the layer's skip count times 4. The skip count is the buffer width minus the rectangle width, in pixels.

There are four modes. Two are copy modes, which read the foreground and write the output. Blend mode reads foreground and background, then writes the foreground word unchanged. Fill mode writes the colour register to every pixel.

Six interrupt causes are kept in a status register. Each cause has its own enable bit and its own write-one-to-clear bit.

Top module: `rect_dma`

Register word index (`reg_addr`):

| Index | Register |
|---|---|
| 0 | control: bit 0 go (reads 1 while busy), bit 1 abort, bits 3:2 mode, bits 13:8 cause enables |
| 1 | status: bits 5:0 |
| 2 | clear: write 1 to clear the matching status bit |
| 3 | size: bits 29:16 pixels per line, bits 15:0 lines |
| 4 / 5 | foreground address / skip |
| 6 / 7 | background address / skip |
| 8 / 9 | output address / skip |
| 10 | fill colour |

Status bits:

| Bit | Cause |
|---|---|
| 0 | transfer done |
| 1 | lookup-table load done |
| 2 | watermark |
| 3 | transfer error |
| 4 | lookup-table access error |
| 5 | configuration error |

No lookup table or watermark logic is present, so bits 1, 2 and 4 are never set.

## Requirements
- R1: After reset, the control, status, size and layer registers read 0, `mem_req` is low and `irq` is low.
- R2: In modes 0 and 1, each pixel is handled as one foreground read followed by one output write of the same word. A job makes exactly pixels×lines reads and pixels×lines writes.
- R3: In mode 2, each pixel is handled as a foreground read, then a background read, then an output write of the foreground word. A job makes 2×pixels×lines reads.
- R4: In mode 3, the fill colour is written to every pixel of the output rectangle, and no reads are made.
- R5: Every layer address starts at its address register and advances by 4 bytes after each pixel. At the end of each line it advances by a further 4×skip bytes.
- R6: A memory request, together with its address and direction, is held unchanged until `mem_gnt` is seen.
- R7: Control bit 0 reads 1 from the cycle after a start until the last write of the last line is granted. It then reads 0, and status bit 0 is set.
- R8: A start while the pixel count or the line count is 0 sets status bit 5 and makes no memory access.
- R9: Writing control bit 1 during a job stops the engine after the current cycle. No further accesses follow, and status bit 0 is not set.
- R10: If `mem_err` is seen with a grant, the job ends and status bit 3 is set. The failing write is not counted as done.
- R11: `irq` is high while any status bit has its enable bit (control bit 8+n for status bit n) set. Writing 1 to clear-register bit n clears only status bit n.
- R12: While a job is busy, writes to the control register change neither the mode nor the enables, and do not restart the job; only abort acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access accepted this cycle |
| mem_err | input | 1 | Accepted access failed |
| mem_rdata | input | 32 | Read data, valid with the grant |
| irq | output | 1 | Interrupt request |

## Verification
A wrong layer address register shows on the very next granted access as a misplaced write. After a line end, it leaves a gap or an overlap in the target buffer, which a full-buffer compare after the job exposes. A wrong phase state shows up in one of three ways: as extra or missing read counts in the same job, as a busy bit that never falls, or as a done flag that is missing or raised after an abort. Flag or enable bits held in the wrong state show on `irq` one cycle after the write that set them.

// File: rtl/rect_dma.sv
module rect_dma #(
  parameter int AW     = 32,
  parameter int PPL_W  = 14,
  parameter int NL_W   = 16,
  parameter int SKIP_W = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata,
  output logic          irq
);
  localparam int BPP    = 4;
  localparam int BPP_SH = $clog2(BPP);
  localparam int NLAY   = 3;
  localparam int NCAUSE = 6;

  typedef enum logic [1:0] {S_IDLE, S_FG, S_BG, S_WR} st_t;

  st_t               state;
  logic [1:0]        mode_r;
  logic [NCAUSE-1:0] en_r, flags;
  logic [PPL_W-1:0]  ppl_r, x;
  logic [NL_W-1:0]   nl_r, y;
  logic [AW-1:0]     base_r [NLAY];
  logic [SKIP_W-1:0] skip_r [NLAY];
  logic [AW-1:0]     cur    [NLAY];
  logic [31:0]       color_r, fg_data;

  logic busy, ctrl_wr, go_wr, abort_wr, clr_wr, zero_sz, eol, eoy;

  assign busy     = state != S_IDLE;
  assign ctrl_wr  = reg_we && reg_addr == 4'd0;
  assign go_wr    = ctrl_wr && reg_wdata[0] && !busy;
  assign abort_wr = ctrl_wr && reg_wdata[1] && busy;
  assign clr_wr   = reg_we && reg_addr == 4'd2;
  assign zero_sz  = ppl_r == '0 || nl_r == '0;
  assign eol      = x == ppl_r - 1'b1;
  assign eoy      = y == nl_r - 1'b1;

  assign mem_req   = busy;
  assign mem_we    = state == S_WR;
  assign mem_addr  = state == S_FG ? cur[0] : (state == S_BG ? cur[1] : cur[2]);
  assign mem_wdata = mode_r == 2'd3 ? color_r : fg_data;
  assign irq       = |(flags & en_r);

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = {18'b0, en_r, 4'b0, mode_r, 1'b0, busy};
      4'd1:    reg_rdata = {26'b0, flags};
      4'd3:    reg_rdata = (32'(ppl_r) << 16) | 32'(nl_r);
      4'd4:    reg_rdata = 32'(base_r[0]);
      4'd5:    reg_rdata = 32'(skip_r[0]);
      4'd6:    reg_rdata = 32'(base_r[1]);
      4'd7:    reg_rdata = 32'(skip_r[1]);
      4'd8:    reg_rdata = 32'(base_r[2]);
      4'd9:    reg_rdata = 32'(skip_r[2]);
      4'd10:   reg_rdata = color_r;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      mode_r  <= '0;
      en_r    <= '0;
      flags   <= '0;
      ppl_r   <= '0;
      nl_r    <= '0;
      x       <= '0;
      y       <= '0;
      color_r <= '0;
      fg_data <= '0;
      for (int l = 0; l < NLAY; l++) begin
        base_r[l] <= '0;
        skip_r[l] <= '0;
        cur[l]    <= '0;
      end
    end else begin
      if (clr_wr) flags <= flags & ~reg_wdata[NCAUSE-1:0];
      if (reg_we) begin
        if (reg_addr == 4'd3) begin
          ppl_r <= reg_wdata[16 +: PPL_W];
          nl_r  <= reg_wdata[NL_W-1:0];
        end
        if (reg_addr == 4'd10) color_r <= reg_wdata;
        for (int l = 0; l < NLAY; l++) begin
          if (reg_addr == 4'(4 + 2*l)) base_r[l] <= AW'(reg_wdata);
          if (reg_addr == 4'(5 + 2*l)) skip_r[l] <= reg_wdata[SKIP_W-1:0];
        end
      end
      if (ctrl_wr && !busy) begin
        mode_r <= reg_wdata[3:2];
        en_r   <= reg_wdata[13:8];
      end
      if (go_wr) begin
        if (zero_sz) flags[5] <= 1'b1;
        else begin
          x <= '0;
          y <= '0;
          for (int l = 0; l < NLAY; l++) cur[l] <= base_r[l];
          state <= reg_wdata[3:2] == 2'd3 ? S_WR : S_FG;
        end
      end

      if (busy && mem_gnt) begin
        if (mem_err) begin
          flags[3] <= 1'b1;
          state    <= S_IDLE;
        end else begin
          case (state)
            S_FG: begin
              fg_data <= mem_rdata;
              state   <= mode_r == 2'd2 ? S_BG : S_WR;
            end
            S_BG: state <= S_WR;
            default: begin
              for (int l = 0; l < NLAY; l++)
                cur[l] <= cur[l] + AW'(BPP) + (eol ? (AW'(skip_r[l]) << BPP_SH) : '0);
              if (eol) begin
                x <= '0;
                y <= y + 1'b1;
              end else x <= x + 1'b1;
              if (eol && eoy) begin
                flags[0] <= 1'b1;
                state    <= S_IDLE;
              end else state <= mode_r == 2'd3 ? S_WR : S_FG;
            end
          endcase
        end
      end

      if (abort_wr) state <= S_IDLE;
    end
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !abort_wr) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R8
  zero_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && zero_sz) |=> (!mem_req && flags[5]));

  // R4
  fill_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mode_r == 2'd3) |-> mem_we);

  // R7
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> ($fell(busy) && $past(mem_we && mem_gnt)));

  // R9
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr |=> (!mem_req && !$rose(flags[0])));

  // R12
  blend_bg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BG) |-> (mode_r == 2'd2));
endmodule

// File: tb/test_rect_dma.sv
module test_rect_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_gnt, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq;

  always #5 clk = ~clk;

  rect_dma i_rect_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_err(mem_err), .mem_rdata(mem_rdata), .irq(irq)
  );

  logic [31:0] mem [256];
  logic [31:0] expm [256];
  int   cyc = 0, nrd = 0, nwr = 0, hold_viol = 0;
  logic init_req = 1'b0, stall = 1'b0, err_arm = 1'b0;
  int   err_at = 0;
  logic [7:0] seed = '0;
  logic pend = 1'b0, pwe = 1'b0;
  logic [31:0] paddr = '0;
  int checks = 0, errors = 0;

  function automatic logic [31:0] pat(input logic [7:0] s, input int i);
    return {8'hA5, s, 6'b0, 10'(i)};
  endfunction

  assign mem_gnt   = stall ? (cyc % 3 != 0) : 1'b1;
  assign mem_rdata = mem[mem_addr[9:2]];
  assign mem_err   = err_arm && mem_req && mem_we && mem_gnt && (nwr == err_at);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (init_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(seed, i);
      nrd <= 0;
      nwr <= 0;
    end else if (mem_req && mem_gnt && !mem_err) begin
      if (mem_we) begin
        mem[mem_addr[9:2]] <= mem_wdata;
        nwr <= nwr + 1;
      end else nrd <= nrd + 1;
    end
    if (pend && (!mem_req || mem_addr != paddr || mem_we != pwe)) hold_viol <= hold_viol + 1;
    pend  <= mem_req && !mem_gnt;
    paddr <= mem_addr;
    pwe   <= mem_we;
  end

  typedef struct packed {
    logic [1:0]  mode;
    logic [13:0] ppl;
    logic [15:0] nl;
    logic [31:0] fga, fgs, bga, bgs, oa, os, col;
    logic        stl;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{2'd0, 14'd3, 16'd2, 32'h000, 32'd2, 32'h000, 32'd0, 32'h200, 32'd5, 32'h0,        1'b0},
    '{2'd1, 14'd1, 16'd4, 32'h040, 32'd0, 32'h000, 32'd0, 32'h300, 32'd3, 32'h0,        1'b1},
    '{2'd2, 14'd4, 16'd3, 32'h080, 32'd1, 32'h100, 32'd2, 32'h240, 32'd0, 32'h0,        1'b1},
    '{2'd3, 14'd5, 16'd2, 32'h000, 32'd0, 32'h000, 32'd0, 32'h380, 32'd1, 32'hDEADBEEF, 1'b0},
    '{2'd3, 14'd1, 16'd1, 32'h000, 32'd0, 32'h000, 32'd0, 32'h3F0, 32'd0, 32'h12345678, 1'b1},
    '{2'd0, 14'd6, 16'd1, 32'h0C0, 32'd9, 32'h000, 32'd0, 32'h200, 32'd0, 32'h0,        1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic init_mem(input logic [7:0] s);
    @(negedge clk);
    seed = s; init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    bit done = 0;
    for (int k = 0; k < 5000 && !done; k++) begin
      rd(4'd0, d);
      if (!d[0]) done = 1;
      else @(negedge clk);
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL R7: actual busy expected idle (timeout)");
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n1;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(4'd0, d); chk("R1 ctrl", d, 32'h0);
    rd(4'd1, d); chk("R1 status", d, 32'h0);
    rd(4'd3, d); chk("R1 size", d, 32'h0);
    rd(4'd8, d); chk("R1 out addr", d, 32'h0);
    chk("R1 mem_req", 32'(mem_req), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      vec_t v;
      int npx, bad;
      string tg;
      v = VEC[i];
      npx = int'(v.ppl) * int'(v.nl);
      stall = v.stl;
      init_mem(8'(i + 1));
      wr(4'd4, v.fga); wr(4'd5, v.fgs);
      wr(4'd6, v.bga); wr(4'd7, v.bgs);
      wr(4'd8, v.oa);  wr(4'd9, v.os);
      wr(4'd10, v.col);
      wr(4'd3, {2'b0, v.ppl, v.nl});
      wr(4'd2, 32'h3F);
      for (int k = 0; k < 256; k++) expm[k] = pat(8'(i + 1), k);
      for (int yy = 0; yy < int'(v.nl); yy++)
        for (int xx = 0; xx < int'(v.ppl); xx++) begin
          int ow, fw;
          ow = int'(v.oa >> 2) + yy * (int'(v.ppl) + int'(v.os)) + xx;
          fw = int'(v.fga >> 2) + yy * (int'(v.ppl) + int'(v.fgs)) + xx;
          expm[ow] = (v.mode == 2'd3) ? v.col : pat(8'(i + 1), fw);
        end
      wr(4'd0, 32'h100 | (32'(v.mode) << 2) | 32'h1);
      if (npx >= 4) begin
        rd(4'd0, d); chk("R7 busy during job", 32'(d[0]), 32'h1);
      end
      wait_idle();
      tg = (v.mode == 2'd2) ? "R3" : ((v.mode == 2'd3) ? "R4" : "R2");
      bad = 0;
      for (int k = 0; k < 256; k++) if (mem[k] !== expm[k]) bad++;
      chk({"R5 ", tg, " buffer mismatches"}, 32'(bad), 32'h0);
      chk({tg, " read count"}, 32'(nrd),
          32'((v.mode == 2'd3) ? 0 : ((v.mode == 2'd2) ? 2 * npx : npx)));
      chk({tg, " write count"}, 32'(nwr), 32'(npx));
      rd(4'd1, d); chk("R7 done flag", d, 32'h1);
      chk("R11 irq on done", 32'(irq), 32'h1);
      wr(4'd2, 32'h1);
      chk("R11 irq after clear", 32'(irq), 32'h0);
    end
    chk("R6 request hold violations", 32'(hold_viol), 32'h0);
    stall = 1'b0;

    // R8 zero pixel count, then zero line count
    init_mem(8'h40);
    wr(4'd3, {2'b0, 14'd0, 16'd3});
    wr(4'd0, 32'h0000_000D);
    repeat (3) @(negedge clk);
    rd(4'd1, d); chk("R8 cfg flag (ppl 0)", d, 32'h20);
    chk("R8 no writes", 32'(nwr), 32'h0);
    chk("R8 no reads", 32'(nrd), 32'h0);
    rd(4'd0, d); chk("R8 not busy", 32'(d[0]), 32'h0);
    chk("R11 masked flag no irq", 32'(irq), 32'h0);
    wr(4'd2, 32'h20);
    wr(4'd3, {2'b0, 14'd2, 16'd0});
    wr(4'd0, 32'h0000_0001);
    repeat (3) @(negedge clk);
    rd(4'd1, d); chk("R8 cfg flag (lines 0)", d, 32'h20);
    chk("R8 no access (lines 0)", 32'(nwr + nrd), 32'h0);
    wr(4'd2, 32'h20);

    // R9 abort and R12 control writes ignored while busy
    init_mem(8'h50);
    wr(4'd8, 32'h0); wr(4'd9, 32'h0); wr(4'd10, 32'hCAFEF00D);
    wr(4'd3, {2'b0, 14'd14, 16'd16});
    wr(4'd0, 32'h0000_010D);
    repeat (4) @(negedge clk);
    wr(4'd0, 32'h0000_3F01);
    rd(4'd0, d); chk("R12 mode/enables kept while busy", d, 32'h0000_010D);
    repeat (4) @(negedge clk);
    wr(4'd0, 32'h0000_0002);
    repeat (2) @(negedge clk);
    n1 = nwr;
    repeat (20) @(negedge clk);
    chk("R9 no writes after abort", 32'(nwr), 32'(n1));
    chk("R9 stopped early", 32'(n1 < 224), 32'h1);
    rd(4'd0, d); chk("R9 not busy", 32'(d[0]), 32'h0);
    rd(4'd1, d); chk("R9 no done flag", d, 32'h0);
    chk("R12 no read in fill after control write", 32'(nrd), 32'h0);

    // R10 memory error on sixth write
    init_mem(8'h60);
    wr(4'd3, {2'b0, 14'd4, 16'd4});
    err_at = 5; err_arm = 1'b1;
    wr(4'd0, 32'h0000_080D);
    wait_idle();
    err_arm = 1'b0;
    chk("R10 writes before error", 32'(nwr), 32'd5);
    rd(4'd1, d); chk("R10 error flag", d, 32'h08);
    chk("R11 irq on error", 32'(irq), 32'h1);
    wr(4'd2, 32'h01);
    rd(4'd1, d); chk("R11 other bit kept", d, 32'h08);
    wr(4'd2, 32'h08);
    rd(4'd1, d); chk("R11 cleared", d, 32'h0);
    chk("R11 irq low", 32'(irq), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule